// File: doc/BRIEF.md
# Write-Only I2C Register Loader

This block is the receive side of an I2C target that only accepts writes into a bank of sixteen byte-wide control registers. It samples the bus clock and data lines with the system clock and detects START and STOP conditions in every state. It then takes in a fixed 7-bit device address, a sub-address byte and any number of data bytes, and acknowledges each accepted byte by pulling the data line low through an open-drain enable.

The sub-address byte sets the first register index and a step flag. When the flag is set, successive data bytes go to successive registers, and the index wraps from the top of the bank back to zero. When the flag is clear, every data byte goes to the same register. Each data byte leaves the block as a one-cycle write strobe that carries its register index and its value. The register bank itself sits outside the block.

Top module: `i2c_regwr_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) is recognised in any state, including in the middle of a byte, and restarts the byte framing at the address byte.
- R2: SDA is taken as data only at SCL rising edges, so SDA changes while SCL is low have no effect on the received value.
- R3: Each byte is eight bits, received most significant bit first.
- R4: For every accepted byte (address, sub-address, data), `sda_oe` goes high after the SCL falling edge that ends the eighth bit. It stays high through the ninth clock and goes low after that clock's falling edge.
- R5: Only the address byte 0x88 is accepted (7-bit address 0x44 with the read/write bit 0). Any other address byte gets no acknowledge, and no further byte gets an acknowledge or a write until the next START.
- R6: In the sub-address byte, bits 3:0 give the first register index, bit 4 is the step flag, and bits 7:5 are ignored.
- R7: With the step flag at 1, data byte k of a transfer goes to register (first + k) mod 16, so the index wraps from 15 to 0.
- R8: With the step flag at 0, every data byte of the transfer goes to the first register index.
- R9: Each data byte gives exactly one `wr_en` pulse, one system clock long, with `wr_addr` and `wr_data` valid in that cycle.
- R10: A rising SDA while SCL is high (STOP) ends the transfer. Bytes clocked after it without a new START get no acknowledge and no write.
- R11: After reset, `sda_oe` and `wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When 1, the pad pulls SDA low (acknowledge) |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 4 | Register index for the write |
| wr_data | output | 8 | Byte to write |

## Verification
The assertions check these properties on every cycle: a START always moves the block to the address phase, and a STOP always returns it to idle. The acknowledge enable can only rise or fall right after an SCL falling edge. A rejected transfer stays silent, write strobes never last more than one cycle, and the register index steps by one or holds according to the step flag. Some behaviour only the bench scenarios can show. These are the exact bytes and register indices that arrive: across every first index with the flag set and with it clear, with wrap-around, with glitches on SDA while SCL is low, with the full sweep of wrong address bytes, with a restart in the middle of a byte and with bytes clocked after a STOP.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA,
    ST_SKIP
  } phase_e;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;
  logic              scl_s;

  // synchronizer chains; idle bus level is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cw_byte.sv
module i2cw_byte #(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          active,
  input  logic          reject,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  output logic          byte_done,
  output logic [NB-1:0] byte_val,
  output logic          ack_oe
);
  localparam int CW = $clog2(NB + 2);
  localparam logic [CW-1:0] C_LAST = CW'(NB - 1);
  localparam logic [CW-1:0] C_DONE = CW'(NB);
  localparam logic [CW-1:0] C_ACK  = CW'(NB + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [NB-1:0] sh_q, sh_d;
  logic          oe_q, oe_d;
  logic          sh_en;

  always_comb begin
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    oe_d      = oe_q;
    sh_en     = 1'b0;
    byte_done = 1'b0;
    if (clr) begin
      cnt_d = '0;
      oe_d  = 1'b0;
    end else if (active) begin
      if (scl_rise && cnt_q < C_DONE) begin
        sh_en     = 1'b1;
        sh_d      = {sh_q[NB-2:0], sda_s};
        byte_done = (cnt_q == C_LAST);
        cnt_d     = (byte_done && reject) ? '0 : cnt_q + 1'b1;
      end else if (scl_fall && cnt_q == C_DONE) begin
        oe_d  = 1'b1;
        cnt_d = C_ACK;
      end else if (scl_fall && cnt_q == C_ACK) begin
        oe_d  = 1'b0;
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      oe_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      oe_q  <= oe_d;
      if (sh_en) sh_q <= sh_d;
    end
  end

  assign byte_val = {sh_q[NB-2:0], sda_s};
  assign ack_oe   = oe_q;

  p_oe_rise_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(scl_fall));
  p_oe_drop_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_q) |-> $past(scl_fall || clr));
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= C_ACK);
endmodule

// File: rtl/i2c_regwr_slave.sv
module i2c_regwr_slave
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h44,
  parameter int         REG_AW      = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [REG_AW-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int NB      = BYTE_BITS;
  localparam int INC_BIT = REG_AW;
  localparam logic [NB-1:0] ADDR_W = {DEV_ADDR, 1'b0};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic byte_done, ack_oe, active, reject, addr_ok;
  logic [NB-1:0] byte_val;

  i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  phase_e            state_q, state_d;
  logic [REG_AW-1:0] ptr_q, ptr_d;
  logic              inc_q, inc_d;
  logic              wr_fire;
  logic              wr_en_q;
  logic [REG_AW-1:0] wr_addr_q;
  logic [7:0]        wr_data_q;

  assign addr_ok = (byte_val == ADDR_W);
  assign active  = (state_q == ST_ADDR) || (state_q == ST_SUB) || (state_q == ST_DATA);
  assign reject  = (state_q == ST_ADDR) && !addr_ok;

  i2cw_byte #(.NB(NB)) u_byte (
    .clk(clk), .rst_n(rst_ni), .clr(start_det | stop_det), .active(active),
    .reject(reject), .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .byte_done(byte_done), .byte_val(byte_val), .ack_oe(ack_oe)
  );

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    inc_d   = inc_q;
    wr_fire = 1'b0;
    if (start_det) begin
      state_d = ST_ADDR;
    end else if (stop_det) begin
      state_d = ST_IDLE;
    end else if (byte_done) begin
      case (state_q)
        ST_ADDR: state_d = addr_ok ? ST_SUB : ST_SKIP;
        ST_SUB: begin
          state_d = ST_DATA;
          ptr_d   = byte_val[REG_AW-1:0];
          inc_d   = byte_val[INC_BIT];
        end
        ST_DATA: begin
          wr_fire = 1'b1;
          if (inc_q) ptr_d = ptr_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ptr_q     <= '0;
      inc_q     <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      inc_q   <= inc_d;
      wr_en_q <= wr_fire;
      if (wr_fire) begin
        wr_addr_q <= ptr_q;
        wr_data_q <= byte_val;
      end
    end
  end

  assign sda_oe  = ack_oe;
  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;

  p_start_to_addr_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    start_det |=> state_q == ST_ADDR);
  p_stop_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    stop_det |=> (state_q == ST_IDLE) && !sda_oe);
  p_skip_silent_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_SKIP) |-> !sda_oe && !wr_en);
  p_wr_single_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |=> !wr_en);
  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_fire && inc_q) |=> ptr_q == REG_AW'($past(ptr_q) + 1'b1));
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_fire && !inc_q) |=> $stable(ptr_q));
endmodule

// File: tb/i2c_regwr_slave_tb.sv
module i2c_regwr_slave_tb;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_line;
  logic sda_oe, wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;

  int checks = 0;
  int errors = 0;
  int wn = 0;
  logic [3:0] wl_a [0:511];
  logic [7:0] wl_d [0:511];
  logic prev_wr = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  i2c_regwr_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // write log and strobe width (R9)
  always @(negedge clk) begin
    if (wr_en) begin
      if (wn < 512) begin
        wl_a[wn] = wr_addr;
        wl_d[wn] = wr_data;
      end
      wn++;
      if (prev_wr) begin
        checks++;
        errors++;
        $display("FAIL R9 strobe width actual=2+ expected=1");
      end
    end
    prev_wr = wr_en;
  end

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(H / 2);
    m_scl = 1'b1; wt(H);
    m_sda = 1'b0; wt(H);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wt(H / 2); m_sda = 1'b0;
    wt(H / 2); m_scl = 1'b1;
    wt(H);     m_sda = 1'b1;
    wt(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      wt(H / 2);
      if (glitch) begin
        m_sda = ~b[i];
        wt(2);
      end
      m_sda = b[i];
      wt(H / 2);
      m_scl = 1'b1;
      wt(H);
      m_scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
    send_bits(b, 8, glitch);
    wt(H / 2); m_sda = 1'b1;
    wt(H / 2); m_scl = 1'b1;
    wt(H / 2); acked = (sda_line == 1'b0);
    wt(H / 2); m_scl = 1'b0;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ak;
    int base;
    logic [7:0] d;
    wt(5);
    rst_n = 1'b1;
    wt(5);
    chk(sda_oe == 1'b0, "R11 sda_oe after reset", int'(sda_oe), 0);
    chk(wr_en == 1'b0, "R11 wr_en after reset", int'(wr_en), 0);

    // stepping sweep over every first index, running past the wrap (R6 R7 R3 R4)
    for (int s = 0; s < 16; s++) begin
      base = wn;
      bus_start();
      send_byte(8'h88, 1'b0, ak);
      chk(ak, "R4 address ack", int'(ak), 1);
      send_byte({3'(s) ^ 3'b101, 1'b1, 4'(s)}, 1'b0, ak);
      chk(ak, "R6 sub-address ack", int'(ak), 1);
      for (int k = 0; k < 18; k++) begin
        send_byte(8'((s * 17 + k * 29 + 3) & 255), 1'b0, ak);
        chk(ak, "R4 data ack", int'(ak), 1);
      end
      bus_stop();
      chk(wn - base == 18, "R9 write count step", wn - base, 18);
      for (int k = 0; k < 18; k++) begin
        chk(wl_a[base + k] == 4'((s + k) % 16), "R7 step index", int'(wl_a[base + k]), (s + k) % 16);
        chk(wl_d[base + k] == 8'((s * 17 + k * 29 + 3) & 255), "R3 data value",
            int'(wl_d[base + k]), (s * 17 + k * 29 + 3) & 255);
      end
    end

    // fixed-index sweep with SDA glitches while SCL low (R8 R2)
    for (int s = 0; s < 16; s++) begin
      base = wn;
      bus_start();
      send_byte(8'h88, 1'b1, ak);
      chk(ak, "R2 address ack with glitches", int'(ak), 1);
      send_byte({3'(15 - s), 1'b0, 4'(s)}, 1'b1, ak);
      chk(ak, "R6 sub-address ack", int'(ak), 1);
      for (int k = 0; k < 4; k++) begin
        d = ~8'((s + k * 7) & 255);
        send_byte(d, 1'b1, ak);
        chk(ak, "R4 data ack", int'(ak), 1);
      end
      bus_stop();
      chk(wn - base == 4, "R9 write count fixed", wn - base, 4);
      for (int k = 0; k < 4; k++) begin
        d = ~8'((s + k * 7) & 255);
        chk(wl_a[base + k] == 4'(s), "R8 fixed index", int'(wl_a[base + k]), s);
        chk(wl_d[base + k] == d, "R2 data despite glitches", int'(wl_d[base + k]), int'(d));
      end
    end

    // every wrong address byte (R5)
    for (int a = 0; a < 256; a++) begin
      if (a == 8'h88) continue;
      base = wn;
      bus_start();
      send_byte(8'(a), 1'b0, ak);
      chk(!ak, "R5 no ack on wrong address", int'(ak), 0);
      send_byte(8'h10, 1'b0, ak);
      chk(!ak, "R5 no ack after reject", int'(ak), 0);
      bus_stop();
      chk(wn == base, "R5 no write after reject", wn - base, 0);
    end

    // START in the middle of a byte restarts framing (R1)
    base = wn;
    bus_start();
    send_byte(8'h88, 1'b0, ak);
    send_bits(8'hFF, 3, 1'b0);
    bus_start();
    send_byte(8'h88, 1'b0, ak);
    chk(ak, "R1 address ack after restart", int'(ak), 1);
    send_byte(8'h13, 1'b0, ak);
    send_byte(8'hA5, 1'b0, ak);
    bus_stop();
    chk(wn - base == 1, "R1 one write after restart", wn - base, 1);
    chk(wl_a[base] == 4'd3, "R1 index after restart", int'(wl_a[base]), 3);
    chk(wl_d[base] == 8'hA5, "R1 data after restart", int'(wl_d[base]), 8'hA5);

    // STOP in the middle of a data byte, then bytes without START (R10)
    base = wn;
    bus_start();
    send_byte(8'h88, 1'b0, ak);
    send_byte(8'h10, 1'b0, ak);
    send_bits(8'hC3, 5, 1'b0);
    bus_stop();
    m_scl = 1'b0;
    send_byte(8'h77, 1'b0, ak);
    chk(!ak, "R10 no ack after stop", int'(ak), 0);
    send_byte(8'h21, 1'b0, ak);
    chk(!ak, "R10 no ack after stop", int'(ak), 0);
    wt(H); m_scl = 1'b1; wt(H);
    chk(wn == base, "R10 no write after stop", wn - base, 0);
    chk(sda_oe == 1'b0, "R10 line released", int'(sda_oe), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule